// File: doc/BRIEF.md
# Micro-Program Sequencer with Relative and Table Branching

This block steps through 16-bit micro-instructions held in an external control store. A routine is started by presenting an entry micro-address on the dispatch inputs while the engine is idle. From then on the sequencer drives the current micro-address on its fetch port and reads back the word stored there in the same cycle. The top three bits of that word give its type, and the type decides what happens next.

Four of the types do data work: register transfer, shift, add/subtract and arithmetic control. The sequencer does not interpret them. It raises an execute strobe and passes the type and the 13 operand bits to the datapath, then moves on to the next address. The remaining types are control flow. A local jump moves by a short signed offset. A far jump or far call goes to one entry of a fixed list of targets. A far call also saves a return point in a single link register. The miscellaneous type covers return, end-of-routine, and no-operation. End-of-routine stops the engine and gives a one-cycle done pulse.

Conditional branches pick one line from a 32-line condition bank and can invert it. Select value 0 means "always".

Top module: `useq_core`

## Requirements
- R1: After reset, `busy`, `done` and `exec_valid` are 0.
- R2: When `disp_valid` is high while `busy` is 0, the next cycle has `busy`=1 and `fetch_addr`=`disp_addr`.
- R3: While busy, a word with type (bits 15:13) 0, 1, 2 or 3 raises `exec_valid` in the same cycle, with `exec_type` equal to bits 15:13 and `exec_operand` equal to bits 12:0. The next address is the current one plus 1.
- R4: Type 5 is a local jump. Bits 12:8 select the condition, bit 6 inverts it, and bits 5:0 are a signed two's-complement offset. If the jump is taken, the next address is current+1+offset; otherwise it is current+1. Condition select 0 is always true, and select k>0 reads `cond_in[k]`.
- R5: The invert bit of a local jump or far jump/call reverses whether it is taken.
- R6: Type 4 is a far jump or call. Bit 12 means call, bits 11:7 select the condition, bits 4:1 give a table index and bit 0 inverts. If taken, the next address is FAR_BASE + index*FAR_STRIDE; otherwise it is current+1.
- R7: A taken far call stores current+1 in the link register. A far call that is not taken leaves the link register unchanged. Type 6 with bits 12:10 = 0 (return) continues at the link register value.
- R8: The link register holds one entry. A second taken call overwrites it, so the next return goes to the most recent call's return point.
- R9: Type 6 with bits 12:10 = 1 (end) clears `busy` at the next edge. `done` is then high for exactly one cycle.
- R10: `disp_valid` while `busy` is 1 has no effect on the micro-address sequence.
- R11: Type 7, and type 6 with bits 12:10 of 2 to 7, advance by 1 without raising `exec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Start a routine (only accepted when idle) |
| disp_addr | input | AW | Entry micro-address |
| fetch_addr | output | AW | Current micro-address |
| fetch_word | input | 16 | Control-store word at `fetch_addr`, same cycle |
| cond_in | input | 32 | Condition bank; line 0 unused (select 0 = always) |
| busy | output | 1 | A routine is running |
| done | output | 1 | One-cycle pulse after end-of-routine |
| exec_valid | output | 1 | Current word is a datapath operation |
| exec_type | output | 3 | Type field of the datapath operation |
| exec_operand | output | 13 | Operand field of the datapath operation |

## Verification
The first pattern is a straight-line routine that ends in a local jump tested against an inverted condition. It is run once with the condition clear and once with it set, which separates a taken jump from one that falls through, and checks the +6 target arithmetic. A loop with a negative offset checks sign extension, and a dispatch attempt made during the loop shows that a busy engine ignores new dispatches. Nested calls followed by returns separate a link register that is overwritten from one that keeps the oldest entry. A call that is not taken, followed by a return, shows whether the link register was written without a taken branch.

// File: rtl/useq_pkg.sv
// Shared definitions for the micro-program sequencer.
// The word format is fixed at 16 bits, so the field widths live here as
// constants. The sizes a chip can tune are parameters of the top module.
package useq_pkg;

    localparam int WORD_W    = 16;
    localparam int COND_W    = 5;
    localparam int OFF_W     = 6;
    localparam int FIDX_W    = 4;
    localparam int OPND_W    = 13;
    localparam int NCOND     = 1 << COND_W;
    localparam int FAR_COUNT = 1 << FIDX_W;

    localparam logic [2:0] TY_FAR   = 3'd4;
    localparam logic [2:0] TY_LOCAL = 3'd5;
    localparam logic [2:0] TY_MISC  = 3'd6;

    localparam logic [2:0] SUB_RET = 3'd0;
    localparam logic [2:0] SUB_END = 3'd1;

    typedef enum logic [2:0] {
        K_EXEC,
        K_FAR,
        K_LOCAL,
        K_RET,
        K_END,
        K_NOP
    } uop_kind_e;

endpackage

// File: rtl/useq_decode.sv
// Word decoder: splits a micro-instruction into its kind and fields.
// Assumes the word is valid whenever the sequencer is busy. The outputs
// are purely combinational.
module useq_decode
    import useq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output uop_kind_e         kind,
    output logic [COND_W-1:0] cond_sel,
    output logic              cond_inv,
    output logic [OFF_W-1:0]  offset,
    output logic [FIDX_W-1:0] far_idx,
    output logic              far_call,
    output logic [2:0]        ty,
    output logic [OPND_W-1:0] operand
);

    assign ty       = word[15:13];
    assign operand  = word[OPND_W-1:0];
    assign offset   = word[OFF_W-1:0];
    assign far_idx  = word[4:1];
    assign far_call = word[12];

    // Classify the word by type field and misc sub-operation.
    always_comb begin
        unique case (ty)
            3'd0, 3'd1, 3'd2, 3'd3: kind = K_EXEC;
            TY_FAR:                 kind = K_FAR;
            TY_LOCAL:               kind = K_LOCAL;
            TY_MISC: begin
                if (word[12:10] == SUB_RET)      kind = K_RET;
                else if (word[12:10] == SUB_END) kind = K_END;
                else                             kind = K_NOP;
            end
            default:                kind = K_NOP;
        endcase
    end

    // Condition fields sit at different places for local and far branches.
    always_comb begin
        if (ty == TY_FAR) begin
            cond_sel = word[11:7];
            cond_inv = word[0];
        end else begin
            cond_sel = word[12:8];
            cond_inv = word[6];
        end
    end

endmodule

// File: rtl/useq_cond.sv
// Condition selector: picks one condition line and optionally inverts it.
// Select value 0 is a constant "true", so line 0 of the bank is never read.
module useq_cond
    import useq_pkg::*;
(
    input  logic [NCOND-1:0]  cond_in,
    input  logic [COND_W-1:0] sel,
    input  logic              inv,
    output logic              hit
);

    logic raw;

    // Select the line, with select 0 meaning unconditional.
    always_comb begin
        raw = (sel == '0) ? 1'b1 : cond_in[sel];
        hit = raw ^ inv;
    end

endmodule

// File: rtl/useq_link.sv
// Single-entry return-address register. A write always replaces the
// current contents; there is no overflow or underflow tracking.
module useq_link #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);

    // Capture the return point on a taken call.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

endmodule

// File: rtl/useq_core.sv
// Micro-program sequencer top. It keeps the micro-address register and the
// busy/done state, and computes the next address from the decoded word.
// Assumes the control store returns the word for fetch_addr in the same
// cycle. The far-target table is built from FAR_BASE and FAR_STRIDE.
module useq_core
    import useq_pkg::*;
#(
    parameter int AW         = 11,
    parameter int FAR_BASE   = 64,
    parameter int FAR_STRIDE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [AW-1:0]     disp_addr,
    output logic [AW-1:0]     fetch_addr,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic [NCOND-1:0]  cond_in,
    output logic              busy,
    output logic              done,
    output logic              exec_valid,
    output logic [2:0]        exec_type,
    output logic [OPND_W-1:0] exec_operand
);

    localparam int SEXT_W = AW - OFF_W;

    logic [AW-1:0]     pc_q;
    logic              busy_q;
    logic              done_q;
    uop_kind_e         kind;
    logic [COND_W-1:0] cond_sel;
    logic              cond_inv;
    logic [OFF_W-1:0]  offset;
    logic [FIDX_W-1:0] far_idx;
    logic              far_call;
    logic [2:0]        ty;
    logic [OPND_W-1:0] operand;
    logic              hit;
    logic [AW-1:0]     seq_addr;
    logic [AW-1:0]     next_addr;
    logic              link_we;
    logic [AW-1:0]     link_q;
    logic              end_now;
    logic [AW-1:0]     far_tab [FAR_COUNT];

    useq_decode u_dec (
        .word     (fetch_word),
        .kind     (kind),
        .cond_sel (cond_sel),
        .cond_inv (cond_inv),
        .offset   (offset),
        .far_idx  (far_idx),
        .far_call (far_call),
        .ty       (ty),
        .operand  (operand)
    );

    useq_cond u_cond (
        .cond_in (cond_in),
        .sel     (cond_sel),
        .inv     (cond_inv),
        .hit     (hit)
    );

    useq_link #(.AW(AW)) u_link (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (link_we),
        .d     (seq_addr),
        .q     (link_q)
    );

    // Fixed far-target list, one constant per entry.
    for (genvar g = 0; g < FAR_COUNT; g++) begin : g_far
        assign far_tab[g] = AW'(FAR_BASE + g * FAR_STRIDE);
    end

    assign seq_addr = pc_q + AW'(1);

    // Next micro-address, link write and end detection.
    always_comb begin
        next_addr = seq_addr;
        link_we   = 1'b0;
        end_now   = 1'b0;
        unique case (kind)
            K_LOCAL: if (hit) next_addr = seq_addr + {{SEXT_W{offset[OFF_W-1]}}, offset};
            K_FAR: begin
                if (hit) begin
                    next_addr = far_tab[far_idx];
                    link_we   = busy_q & far_call;
                end
            end
            K_RET:   next_addr = link_q;
            K_END:   end_now   = busy_q;
            default: next_addr = seq_addr;
        endcase
    end

    // Address, busy and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                pc_q <= next_addr;
                if (end_now) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (disp_valid) begin
                pc_q   <= disp_addr;
                busy_q <= 1'b1;
            end
        end
    end

    assign fetch_addr   = pc_q;
    assign busy         = busy_q;
    assign done         = done_q;
    assign exec_valid   = busy_q && (kind == K_EXEC);
    assign exec_type    = ty;
    assign exec_operand = operand;

endmodule

// File: rtl/useq_core_chk.sv
// Property checker for useq_core, attached with bind. It decodes the
// fetched word on its own from the port values.
module useq_core_chk
    import useq_pkg::*;
#(
    parameter int AW         = 11,
    parameter int FAR_BASE   = 64,
    parameter int FAR_STRIDE = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     fetch_addr,
    input logic [WORD_W-1:0] fetch_word,
    input logic              busy,
    input logic              done,
    input logic              exec_valid
);

    logic        is_exec;
    logic        is_end;
    logic        loc_always;
    logic        loc_never;
    logic        far_always;
    logic [AW-1:0] loc_off;
    logic [AW-1:0] far_dest;

    assign is_exec    = fetch_word[15] == 1'b0;
    assign is_end     = fetch_word[15:13] == TY_MISC && fetch_word[12:10] == SUB_END;
    assign loc_always = fetch_word[15:13] == TY_LOCAL && fetch_word[12:8] == 5'd0 && !fetch_word[6];
    assign loc_never  = fetch_word[15:13] == TY_LOCAL && fetch_word[12:8] == 5'd0 && fetch_word[6];
    assign far_always = fetch_word[15:13] == TY_FAR && fetch_word[11:7] == 5'd0 && !fetch_word[0];
    assign loc_off    = AW'(signed'(fetch_word[5:0]));
    assign far_dest   = AW'(FAR_BASE + int'(fetch_word[4:1]) * FAR_STRIDE);

    assert_exec_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> busy);

    assert_exec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_exec) |=> (busy && fetch_addr == $past(fetch_addr) + AW'(1)));

    assert_local_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && loc_always) |=> (fetch_addr == $past(fetch_addr) + AW'(1) + $past(loc_off)));

    assert_local_inverted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && loc_never) |=> (fetch_addr == $past(fetch_addr) + AW'(1)));

    assert_far_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && far_always) |=> (fetch_addr == $past(far_dest)));

    assert_end_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_end) |=> (done && !busy));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_end) |=> busy);

endmodule

bind useq_core useq_core_chk #(
    .AW         (AW),
    .FAR_BASE   (FAR_BASE),
    .FAR_STRIDE (FAR_STRIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_addr (fetch_addr),
    .fetch_word (fetch_word),
    .busy       (busy),
    .done       (done),
    .exec_valid (exec_valid)
);

// File: tb/tb_useq_core.sv
`timescale 1ns/1ps
module tb_useq_core;

    localparam int AW = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [AW-1:0] disp_addr = '0;
    logic [AW-1:0] fetch_addr;
    logic [15:0] fetch_word;
    logic [31:0] cond_in = '0;
    logic        busy, done, exec_valid;
    logic [2:0]  exec_type;
    logic [12:0] exec_operand;
    logic [15:0] rom [2048];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign fetch_word = rom[fetch_addr];

    useq_core #(.AW(AW), .FAR_BASE(64), .FAR_STRIDE(32)) dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_addr(disp_addr),
        .fetch_addr(fetch_addr), .fetch_word(fetch_word), .cond_in(cond_in),
        .busy(busy), .done(done), .exec_valid(exec_valid),
        .exec_type(exec_type), .exec_operand(exec_operand)
    );

    function automatic logic [15:0] w_local(int c, bit inv, int off);
        logic [5:0] o = off[5:0];
        logic [4:0] cs = c[4:0];
        return {3'b101, cs, 1'b0, inv, o};
    endfunction

    function automatic logic [15:0] w_far(bit call, int c, int idx, bit inv);
        logic [4:0] cs = c[4:0];
        logic [3:0] ix = idx[3:0];
        return {3'b100, call, cs, 2'b00, ix, inv};
    endfunction

    function automatic logic [15:0] w_misc(int s);
        logic [2:0] ss = s[2:0];
        return {3'b110, ss, 10'd0};
    endfunction

    function automatic logic [15:0] w_exec(int t, int op);
        logic [2:0] tt = t[2:0];
        logic [12:0] oo = op[12:0];
        return {tt, oo};
    endfunction

    function automatic int far_addr(int idx);
        return 64 + idx * 32;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic dispatch(int addr);
        disp_valid = 1'b1;
        disp_addr  = AW'(addr);
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    task automatic expect_pc(int exp, string req);
        chk(busy == 1'b1, {req, " busy"}, int'(busy), 1);
        chk(int'(fetch_addr) == exp, {req, " addr"}, int'(fetch_addr), exp);
        @(negedge clk);
    endtask

    task automatic expect_end(string req);
        chk(busy == 1'b0, {req, " busy low after end"}, int'(busy), 0);
        chk(done == 1'b1, {req, " done pulse"}, int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, {req, " done one cycle"}, int'(done), 0);
    endtask

    // R1: reset state
    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(exec_valid == 1'b0, "R1 exec_valid", int'(exec_valid), 0);
    endtask

    // R2 R3 R4 R5 R11: straight line then local jump on inverted condition
    task automatic t_local(bit cbit);
        cond_in[3] = cbit;
        dispatch(200);
        chk(exec_valid == 1'b1, "R3 exec strobe transfer", int'(exec_valid), 1);
        chk(exec_type == 3'd0, "R3 exec type", int'(exec_type), 0);
        chk(exec_operand == 13'h0123, "R3 operand", int'(exec_operand), 'h123);
        expect_pc(200, "R2 entry");
        chk(exec_valid == 1'b0, "R11 type 7 no strobe", int'(exec_valid), 0);
        expect_pc(201, "R11 type 7 advance");
        chk(exec_type == 3'd1 && exec_valid, "R3 shift type", int'(exec_type), 1);
        chk(exec_operand == 13'h0456, "R3 shift operand", int'(exec_operand), 'h456);
        expect_pc(202, "R3 advance");
        expect_pc(203, "R4 jump word");
        if (!cbit) begin
            expect_pc(210, "R4 R5 inverted clear condition taken +6");
        end else begin
            chk(exec_valid == 1'b0, "R11 misc nop no strobe", int'(exec_valid), 0);
            expect_pc(204, "R4 R5 inverted set condition falls through");
            expect_pc(205, "R11 misc nop advance");
            for (int a = 206; a <= 210; a++) expect_pc(a, "R3 advance");
        end
        expect_end("R9");
    endtask

    // R4 R10: negative offset loop with a dispatch attempt while busy
    task automatic t_loop();
        cond_in[5] = 1'b1;
        dispatch(299);
        expect_pc(299, "R2 entry");
        disp_valid = 1'b1;
        disp_addr  = AW'(1000);
        expect_pc(300, "R4 loop word");
        expect_pc(299, "R4 R10 back by offset -2, dispatch ignored");
        disp_valid = 1'b0;
        cond_in[5] = 1'b0;
        expect_pc(300, "R10 sequence unchanged");
        expect_pc(301, "R4 not taken");
        expect_end("R9");
    endtask

    // R6 R7: far call and return
    task automatic t_call();
        dispatch(400);
        expect_pc(400, "R2 entry");
        expect_pc(far_addr(3), "R6 far call target");
        expect_pc(far_addr(3) + 1, "R3 advance");
        expect_pc(401, "R7 return to call+1");
        expect_end("R9");
    endtask

    // R8: nested call overwrites the single link entry
    task automatic t_nested();
        dispatch(500);
        expect_pc(500, "R2 entry");
        expect_pc(far_addr(4), "R6 first call");
        expect_pc(far_addr(5), "R6 second call");
        expect_pc(far_addr(4) + 1, "R8 return to latest call point");
        expect_end("R9");
    endtask

    // R5 R6: conditional far jump, plain and inverted
    task automatic t_farjump();
        cond_in[7] = 1'b0;
        dispatch(600);
        expect_pc(600, "R2 entry");
        expect_pc(601, "R6 far jump not taken");
        expect_pc(far_addr(2), "R5 R6 inverted far jump taken");
        expect_end("R9");
    endtask

    // R7: an untaken call leaves the link register as it was
    task automatic t_untaken_call();
        cond_in[7] = 1'b0;
        dispatch(700);
        expect_pc(700, "R2 entry");
        expect_pc(701, "R7 call not taken");
        expect_pc(far_addr(4) + 1, "R7 link unchanged by untaken call");
        expect_end("R9");
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) rom[i] = 16'hE000;
        rom[200] = w_exec(0, 'h123);
        rom[201] = 16'hE000;
        rom[202] = w_exec(1, 'h456);
        rom[203] = w_local(3, 1'b1, 6);
        rom[204] = w_misc(2);
        rom[205] = w_exec(2, 'h011);
        rom[210] = w_misc(1);
        rom[299] = w_exec(2, 'h0AA);
        rom[300] = w_local(5, 1'b0, -2);
        rom[301] = w_misc(1);
        rom[400] = w_far(1'b1, 0, 3, 1'b0);
        rom[far_addr(3)]     = w_exec(3, 'h007);
        rom[far_addr(3) + 1] = w_misc(0);
        rom[401] = w_misc(1);
        rom[500] = w_far(1'b1, 0, 4, 1'b0);
        rom[far_addr(4)]     = w_far(1'b1, 0, 5, 1'b0);
        rom[far_addr(5)]     = w_misc(0);
        rom[far_addr(4) + 1] = w_misc(1);
        rom[600] = w_far(1'b0, 7, 2, 1'b0);
        rom[601] = w_far(1'b0, 7, 2, 1'b1);
        rom[far_addr(2)] = w_misc(1);
        rom[700] = w_far(1'b1, 7, 6, 1'b0);
        rom[701] = w_misc(0);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_local(1'b0);
        t_local(1'b1);
        t_loop();
        t_call();
        t_nested();
        t_farjump();
        t_untaken_call();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule